// File: doc/BRIEF.md
# Transition-Filtered Status Event Group

This block is one 16-bit status register group of the kind that feeds a service-request summary. Every cycle it watches a live condition vector. It latches a bit into a sticky event register whenever that condition bit changes in a direction the software has allowed. Rising changes pass through a rising-edge mask and falling changes pass through a separate falling-edge mask. An enable mask then selects which latched events count toward a single summary bit. Software sees that bit as the group's contribution to a higher-level status byte.

Software sets up the group through a small write port. The port has a 2-bit selector and a 16-bit data word, and it loads the rising mask, the falling mask or the enable mask. Software reads the event register through a read strobe. The read returns the current contents, and at the next clock edge the register is cleared, which also drops the summary bit. Address decoding and the routing of the summary into a status byte belong to the surrounding logic.

For example, to raise the summary on a rising edge of condition bit 10, load 0x0400 into both the rising mask and the enable mask. To raise it on rising edges of bits 0, 1 or 4, load 0x0013 into both.

Top module: `stat_evt_grp`

## Requirements
- R1: After reset the event register, the rising mask, the falling mask and the enable mask are all zero, so `rd_data_o` reads 0 and `summary_o` is 0.
- R2: A 0-to-1 change of `cond_i[i]` between two consecutive clock edges sets event bit i at the second edge, and only if bit i of the rising mask (write selector 0) is 1.
- R3: A 1-to-0 change of `cond_i[i]` between two consecutive clock edges sets event bit i at the second edge, and only if bit i of the falling mask (write selector 1) is 1.
- R4: `summary_o` is 1 exactly when at least one event bit is 1 and the same bit of the enable mask (write selector 2) is 1. A latched event whose enable bit is 0 leaves `summary_o` at 0.
- R5: While `rd_en_i` is high, `rd_data_o` shows the event register contents. At the clock edge that ends the read cycle, every event bit is cleared, so `summary_o` falls unless a new edge is latched in that same cycle.
- R6: Once set, an event bit stays set until a read clears it, even if the condition bit returns to its former level.
- R7: An edge that passes its filter in the same cycle as a clearing read is kept. After that edge the event register holds exactly the edges latched in the read cycle.
- R8: A write with `wr_en_i` high loads `wr_data_i` into the mask chosen by `wr_sel_i` at the next clock edge. Selector value 3 changes no mask. Mask changes apply to edges from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_i | input | 16 | Live condition vector |
| wr_en_i | input | 1 | Mask write strobe |
| wr_sel_i | input | 2 | Mask select: 0 rising, 1 falling, 2 enable, 3 none |
| wr_data_i | input | 16 | Mask write data |
| rd_en_i | input | 1 | Event read strobe; clears the event register at the next edge |
| rd_data_o | output | 16 | Current event register contents |
| summary_o | output | 1 | OR of event bits that are enabled |

## Verification
A clearing read and the capture of a new filtered edge can land in the same cycle. The design must drop the old events and keep the new one. The bench provokes this by driving a rising edge on an unlatched, filter-passing condition bit in the very cycle that the read strobe is high. It expects that read to return only the older events. The following read must return exactly the bit that changed, with the summary following its enable bit. A checker property also requires the register after any read to equal the edges latched during that read cycle.

// File: rtl/stat_evt_pkg.sv
package stat_evt_pkg;

    typedef enum logic [1:0] {
        MSK_RISE = 2'd0,
        MSK_FALL = 2'd1,
        MSK_ENAB = 2'd2,
        MSK_NONE = 2'd3
    } msk_sel_e;

endpackage

// File: rtl/stat_edge_filt.sv
module stat_edge_filt #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] prev_i,
    input  logic [WIDTH-1:0] rise_msk_i,
    input  logic [WIDTH-1:0] fall_msk_i,
    output logic [WIDTH-1:0] hit_o
);

    // One qualifier per bit; rising and falling paths are gated independently.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic went_up;
        logic went_dn;
        assign went_up  = cur_i[b] & ~prev_i[b];
        assign went_dn  = ~cur_i[b] & prev_i[b];
        assign hit_o[b] = (went_up & rise_msk_i[b]) | (went_dn & fall_msk_i[b]);
    end

endmodule

// File: rtl/stat_evt_summ.sv
module stat_evt_summ #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] evt_i,
    input  logic [WIDTH-1:0] enab_i,
    output logic             summ_o
);

    assign summ_o = |(evt_i & enab_i);

endmodule

// File: rtl/stat_evt_grp.sv
module stat_evt_grp
    import stat_evt_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cond_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_en_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             summary_o
);

    typedef struct packed {
        logic [WIDTH-1:0] cond;
        logic [WIDTH-1:0] evt;
        logic [WIDTH-1:0] rise;
        logic [WIDTH-1:0] fall;
        logic [WIDTH-1:0] enab;
    } grp_st_t;

    grp_st_t st_d, st_q;

    logic [WIDTH-1:0] cond_q;
    logic [WIDTH-1:0] rise_q;
    logic [WIDTH-1:0] fall_q;
    logic [WIDTH-1:0] enab_q;
    logic [WIDTH-1:0] evt_q;
    logic [WIDTH-1:0] edge_hit;

    assign cond_q = st_q.cond;
    assign rise_q = st_q.rise;
    assign fall_q = st_q.fall;
    assign enab_q = st_q.enab;
    assign evt_q  = st_q.evt;

    stat_edge_filt #(.WIDTH(WIDTH)) u_filt (
        .cur_i      (cond_i),
        .prev_i     (cond_q),
        .rise_msk_i (rise_q),
        .fall_msk_i (fall_q),
        .hit_o      (edge_hit)
    );

    stat_evt_summ #(.WIDTH(WIDTH)) u_summ (
        .evt_i  (evt_q),
        .enab_i (enab_q),
        .summ_o (summary_o)
    );

    assign rd_data_o = evt_q;

    always_comb begin
        st_d      = st_q;
        st_d.cond = cond_i;
        // A read wipes old events; edges of this same cycle survive it.
        st_d.evt  = (rd_en_i ? '0 : st_q.evt) | edge_hit;
        if (wr_en_i) begin
            unique case (msk_sel_e'(wr_sel_i))
                MSK_RISE: st_d.rise = wr_data_i;
                MSK_FALL: st_d.fall = wr_data_i;
                MSK_ENAB: st_d.enab = wr_data_i;
                MSK_NONE: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/stat_evt_grp_chk.sv
module stat_evt_grp_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] cond_i,
    input logic             rd_en_i,
    input logic [WIDTH-1:0] rd_data_o,
    input logic             summary_o,
    input logic [WIDTH-1:0] cond_q,
    input logic [WIDTH-1:0] rise_q,
    input logic [WIDTH-1:0] fall_q,
    input logic [WIDTH-1:0] enab_q,
    input logic [WIDTH-1:0] edge_hit
);

    logic [WIDTH-1:0] ref_edge;
    assign ref_edge = (cond_i & ~cond_q & rise_q) | (~cond_i & cond_q & fall_q);

    // R1: state is clear at the first edge after reset release
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_data_o == '0 && !summary_o));

    // R2 / R3: a newly set event bit must come from a qualified edge
    a_r2_r3_new_bits_filtered: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data_o & ~$past(rd_data_o) & ~$past(ref_edge)) == '0));

    // R4: summary tracks enabled events
    a_r4_summary_match: assert property (@(posedge clk) disable iff (!rst_n)
        summary_o == ((rd_data_o & enab_q) != '0));

    // R6: without a read no event bit drops
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> ((rd_data_o & $past(rd_data_o)) == $past(rd_data_o)));

    // R5 / R7: after a read only the edges of the read cycle remain
    a_r7_read_keeps_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> (rd_data_o == $past(edge_hit)));

endmodule

bind stat_evt_grp stat_evt_grp_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_i    (cond_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .summary_o (summary_o),
    .cond_q    (cond_q),
    .rise_q    (rise_q),
    .fall_q    (fall_q),
    .enab_q    (enab_q),
    .edge_hit  (edge_hit)
);

// File: tb/stat_evt_grp_test.sv
module stat_evt_grp_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cond_i = '0;
    logic         wr_en_i = 1'b0;
    logic [1:0]   wr_sel_i = 2'd0;
    logic [W-1:0] wr_data_i = '0;
    logic         rd_en_i = 1'b0;
    logic [W-1:0] rd_data_o;
    logic         summary_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // expected {summary, data} and requirement tag per read
    logic [W:0] exp_q[$];
    string      tag_q[$];

    // independent bench model
    logic [W-1:0] m_evt = '0, m_rise = '0, m_fall = '0, m_enab = '0, m_prev = '0;

    always #10 clk = ~clk;

    stat_evt_grp uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_i    (cond_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .rd_data_o (rd_data_o),
        .summary_o (summary_o)
    );

    function automatic logic [W-1:0] mdl_edges(logic [W-1:0] cur);
        return (cur & ~m_prev & m_rise) | (~cur & m_prev & m_fall);
    endfunction

    // one cycle: drive condition, optionally read; model advances at the edge
    task automatic step(input logic [W-1:0] c, input logic rd, input string tag);
        @(posedge clk); #2;
        cond_i  = c;
        rd_en_i = rd;
        if (rd) begin
            exp_q.push_back({|(m_evt & m_enab), m_evt});
            tag_q.push_back(tag);
        end
        m_evt  = (rd ? '0 : m_evt) | mdl_edges(c);
        m_prev = c;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
        @(posedge clk); #2;
        rd_en_i   = 1'b0;
        wr_en_i   = 1'b1;
        wr_sel_i  = sel;
        wr_data_i = d;
        m_evt  = m_evt | mdl_edges(cond_i);
        m_prev = cond_i;
        case (sel)
            2'd0: m_rise = d;
            2'd1: m_fall = d;
            2'd2: m_enab = d;
            default: ;
        endcase
        @(posedge clk); #2;
        wr_en_i = 1'b0;
        m_evt  = m_evt | mdl_edges(cond_i);
        m_prev = cond_i;
    endtask

    // monitor: compare on every read cycle
    always @(negedge clk) begin
        cyc++;
        if (rst_n && rd_en_i) begin
            logic [W:0] e;
            string t;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read: actual %h expected none", {summary_o, rd_data_o});
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({summary_o, rd_data_o} !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual summ=%b data=%h expected summ=%b data=%h",
                             t, summary_o, rd_data_o, e[W], e[W-1:0]);
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        // R1: reset state
        step(16'h0000, 1'b1, "R1 reset value");
        step(16'h0000, 1'b0, "idle");
        // R2, R4: rising bit 10 with rise and enable masks at 0x0400
        wr(2'd0, 16'h0400);
        wr(2'd2, 16'h0400);
        step(16'h0400, 1'b0, "R2 edge");
        step(16'h0400, 1'b1, "R2 R4 bit10 rise sets summary");
        // R5: register cleared, summary fallen
        step(16'h0400, 1'b1, "R5 cleared after read");
        // R3: falling edge with falling mask zero ignored
        step(16'h0000, 1'b0, "R3 fall unfiltered");
        step(16'h0000, 1'b1, "R3 fall ignored when mask clear");
        // R8: selector 3 changes nothing; bits 0,1,4 armed
        wr(2'd3, 16'hFFFF);
        step(16'h0001, 1'b0, "R8 none-select");
        step(16'h0000, 1'b1, "R8 selector 3 ignored");
        wr(2'd0, 16'h0013);
        wr(2'd2, 16'h0013);
        // R6: bit 4 pulses and returns low; event must stay
        step(16'h0010, 1'b0, "R6");
        step(16'h0000, 1'b0, "R6");
        step(16'h0001, 1'b0, "R6");
        step(16'h0003, 1'b0, "R6");
        step(16'h0003, 1'b0, "R6");
        step(16'h0003, 1'b1, "R6 sticky bits 0,1,4");
        step(16'h0003, 1'b1, "R5 clear after multi-bit read");
        // R3: falling mask bit 1
        wr(2'd1, 16'h0002);
        step(16'h0001, 1'b0, "R3 fall");
        step(16'h0000, 1'b1, "R3 bit1 fall latched, bit0 not");
        // R4: event latched but not enabled
        wr(2'd0, 16'h8020);
        wr(2'd2, 16'h0000);
        step(16'h8000, 1'b0, "R4");
        step(16'h8000, 1'b1, "R4 disabled event keeps summary low");
        // R7: edge on bit 5 in the same cycle as the read
        wr(2'd2, 16'h0020);
        step(16'h8000, 1'b0, "R7 prep");
        step(16'h8000, 1'b1, "R7 prep clear");
        step(16'h8000, 1'b0, "R7 prep");
        step(16'hC000, 1'b0, "R7 unfiltered bit14");
        step(16'hC020, 1'b1, "R7 read during edge returns old");
        step(16'hC020, 1'b1, "R7 edge kept after read");
        step(16'hC020, 1'b1, "R5 empty again");
        // R2: rising edge with mask clear is ignored
        wr(2'd0, 16'h0000);
        step(16'hFFFF, 1'b0, "R2 masked");
        step(16'hFFFF, 1'b1, "R2 masked rises ignored");
        step(16'h0000, 1'b0, "idle");
        @(posedge clk); #2;
        rd_en_i = 1'b0;
        repeat (2) @(posedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R5 reads missing: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end

    initial begin
        wait (cyc > 5000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        finish_run();
    end

endmodule